// File: doc/BRIEF.md
# Memory Self-Test Traffic Driver

This block sits on the user side of a memory controller and checks the memory attached behind it. After reset it stays quiet until the controller reports that initialisation is finished. It then runs up to three test phases in a fixed order. Each phase writes a set of locations, reads the same locations back and compares every returned word with a value computed from its address. One sticky flag records any mismatch, and a second flag reports that the whole run has ended.

Each phase has its own enable input. The sequential phase sweeps a row × bank × column region whose extent is set by parameters. The byte-lane phase checks that byte enables really mask data: it writes every location in full, then overwrites exactly one byte lane per location, and reads back the merged words. The address phase walks a single one through every address bit, so that shorted or stuck address lines show up. Reads are pipelined. A small queue of expected words bounds how many reads can be in flight, and returned data is checked in order.

Top module: `memtest_driver`

## Requirements
- R1: While `rst` is high, `wr_req_o`, `rd_req_o`, `done_o` and `fail_o` are low. They stay low in the first cycle after `rst` falls.
- R2: After reset, no request is presented until `init_done_i` has been sampled high.
- R3: A request stays on the outputs, unchanged, until it is sampled with `req_ready_i` high. The next request may appear in the following cycle. `wr_req_o` and `rd_req_o` are never high together, and `size_o` is always 1.
- R4: The sequential phase writes every location with row < MAX_ROW, bank < MAX_BANK and column < MAX_COL. The address is {row, bank, column} with the column in the least significant bits. The column varies fastest, then the bank, then the row. All byte enables are set. The data is P(address), where P is the 32-bit word (A × 0x9E3779B1 mod 2^32) XOR 0x5A5AA5A5 for the address A zero-extended to 32 bits, and data byte b takes byte (b mod 4) of that word. The phase then reads the same addresses in the same order.
- R5: With `en_seq_i` low, the sequential phase issues no request.
- R6: The byte-lane phase covers addresses 0 to MASK_LOCS-1 in ascending order, in three passes. The first pass writes P(address) with all byte enables set. The second pass writes the complement of P(address) with only byte enable bit (address mod bytes-per-word) set. The third pass reads back and expects P(address) with that one byte inverted.
- R7: With `en_mask_i` low, the byte-lane phase issues no request.
- R8: The address phase writes addresses 1<<i for i = 0 up to the address width minus 1, in ascending i. It uses all byte enables, and the data is the address zero-extended. It then reads the same addresses back in the same order, expecting the same values.
- R9: With `en_addr_i` low, the address phase issues no request.
- R10: Enabled phases run in the order sequential, byte-lane, address. No write of a later phase is issued before every read of the earlier phase has returned.
- R11: A read beat that differs from its expected value, or that arrives with no read outstanding, sets `fail_o` in the following cycle. `fail_o` then stays high until reset.
- R12: `done_o` rises only after the last read of the last enabled phase has returned, or right after start when no phase is enabled. It then stays high, and no request follows it.
- R13: The number of accepted reads whose data has not yet returned never exceeds RD_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_done_i | input | 1 | Controller finished initialisation |
| en_seq_i | input | 1 | Enable for the sequential sweep phase |
| en_mask_i | input | 1 | Enable for the byte-lane phase |
| en_addr_i | input | 1 | Enable for the walking-address phase |
| req_ready_i | input | 1 | Controller accepts the presented request this cycle |
| wr_req_o | output | 1 | Write request |
| rd_req_o | output | 1 | Read request |
| addr_o | output | ROW_W+BANK_W+COL_W | Word address {row, bank, column} |
| size_o | output | SIZE_W | Burst size in beats (always 1) |
| wdata_o | output | DW | Write data |
| be_o | output | DW/8 | Byte enables for the write |
| rdata_valid_i | input | 1 | Read data beat valid |
| rdata_i | input | DW | Read data |
| done_o | output | 1 | All enabled phases finished |
| fail_o | output | 1 | Sticky mismatch flag |

## Verification
The assertions assume that the controller returns exactly one read beat per accepted read, in the order the reads were accepted, and never before the cycle after acceptance. They also assume that the enable inputs do not change during a run. The bench memory model returns beats in order from a queue filled when reads are accepted, with a latency of at least two cycles. It holds the enables constant between resets. The one deliberate departure is a single corrupted beat, used to exercise the sticky fail flag. That beat keeps the beat count and ordering intact.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [2:0] {
    PH_START,
    PH_SEQ,
    PH_MASK,
    PH_ADDR,
    PH_END
  } phase_e;

  typedef enum logic [1:0] {
    ST_WFULL,
    ST_WLANE,
    ST_READ
  } stage_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_NEXT,
    S_WR1,
    S_WR2,
    S_RD,
    S_DRAIN,
    S_DONE
  } fsm_e;

endpackage

// File: rtl/memtest_phase_sel.sv
module memtest_phase_sel
  import memtest_pkg::*;
(
  input  phase_e cur_i,
  input  logic   en_seq_i,
  input  logic   en_mask_i,
  input  logic   en_addr_i,
  output phase_e nxt_o
);

  // Fixed order: sequential, byte-lane, address; skipped phases fall through.
  always_comb begin
    nxt_o = PH_END;
    case (cur_i)
      PH_START: begin
        if (en_seq_i)       nxt_o = PH_SEQ;
        else if (en_mask_i) nxt_o = PH_MASK;
        else if (en_addr_i) nxt_o = PH_ADDR;
      end
      PH_SEQ: begin
        if (en_mask_i)      nxt_o = PH_MASK;
        else if (en_addr_i) nxt_o = PH_ADDR;
      end
      PH_MASK: begin
        if (en_addr_i)      nxt_o = PH_ADDR;
      end
      default: nxt_o = PH_END;
    endcase
  end

endmodule

// File: rtl/memtest_pattern.sv
module memtest_pattern
  import memtest_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 3,
  parameter int MAX_ROW   = 2,
  parameter int MAX_BANK  = 2,
  parameter int MAX_COL   = 4,
  parameter int MASK_LOCS = 8,
  parameter int DW        = 32,
  parameter int IDX_W     = 5
) (
  input  phase_e                          phase_i,
  input  stage_e                          stage_i,
  input  logic [IDX_W-1:0]                idx_i,
  output logic [ROW_W+BANK_W+COL_W-1:0]   addr_o,
  output logic [DW-1:0]                   wdata_o,
  output logic [DW/8-1:0]                 be_o,
  output logic [DW-1:0]                   exp_o,
  output logic [IDX_W-1:0]                count_o
);

  localparam int AW    = ROW_W + BANK_W + COL_W;
  localparam int NB    = DW / 8;
  localparam int N_SEQ = MAX_ROW * MAX_BANK * MAX_COL;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    logic [31:0]   w;
    logic [DW-1:0] r;
    w = (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_A5A5;
    for (int b = 0; b < NB; b++) r[8*b +: 8] = w[8*(b%4) +: 8];
    return r;
  endfunction

  logic [31:0]   li;
  logic [AW-1:0] mask_addr;
  logic [DW-1:0] mask_base;
  logic [NB-1:0] lane_be;
  logic [DW-1:0] lane_bits;

  assign li        = 32'(idx_i);
  assign mask_addr = AW'(li);
  assign mask_base = pat(mask_addr);
  assign lane_be   = NB'(1) << (li % NB);

  // Expand the one-hot lane select to a bit mask over the data word.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_bits[8*b +: 8] = {8{lane_be[b]}};
  end

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    be_o    = '1;
    exp_o   = '0;
    count_o = '0;
    case (phase_i)
      PH_SEQ: begin
        addr_o  = {ROW_W'(li / (MAX_COL * MAX_BANK)),
                   BANK_W'((li / MAX_COL) % MAX_BANK),
                   COL_W'(li % MAX_COL)};
        wdata_o = pat(addr_o);
        exp_o   = wdata_o;
        count_o = IDX_W'(N_SEQ);
      end
      PH_MASK: begin
        addr_o  = mask_addr;
        count_o = IDX_W'(MASK_LOCS);
        case (stage_i)
          ST_WFULL: begin
            wdata_o = mask_base;
            exp_o   = mask_base;
          end
          ST_WLANE: begin
            wdata_o = ~mask_base;
            be_o    = lane_be;
            exp_o   = mask_base;
          end
          default: begin
            wdata_o = mask_base;
            exp_o   = mask_base ^ lane_bits;
          end
        endcase
      end
      PH_ADDR: begin
        addr_o  = AW'(1) << li;
        wdata_o = DW'(addr_o);
        exp_o   = wdata_o;
        count_o = IDX_W'(AW);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/memtest_rdcheck.sv
module memtest_rdcheck #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_i,
  input  logic [DW-1:0]              push_data_i,
  input  logic                       beat_i,
  input  logic [DW-1:0]              beat_data_i,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o,
  output logic                       fail_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          fail_q;
  logic          pop;
  logic          bad;

  assign pop = beat_i && (cnt_q != '0);
  assign bad = beat_i && ((cnt_q == '0) || (beat_data_i != mem_q[rptr_q]));

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push_i) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop)    rptr_q <= (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop);
      if (bad) fail_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign fail_o = fail_q;

  // R13: no push into a full queue of expected words
  p_no_overflow_r13: assert property (@(posedge clk) disable iff (rst)
    push_i |-> ((cnt_q < CW'(DEPTH)) || pop));

  // R11: mismatch flag is sticky
  p_fail_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    fail_q |=> fail_q);

  // R11: a bad beat is reported in the following cycle
  p_fail_follows_r11: assert property (@(posedge clk) disable iff (rst)
    bad |=> fail_q);

endmodule

// File: rtl/memtest_driver.sv
module memtest_driver
  import memtest_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 3,
  parameter int MAX_ROW   = 2,
  parameter int MAX_BANK  = 2,
  parameter int MAX_COL   = 4,
  parameter int MASK_LOCS = 8,
  parameter int DW        = 32,
  parameter int RD_DEPTH  = 4,
  parameter int SIZE_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          init_done_i,
  input  logic                          en_seq_i,
  input  logic                          en_mask_i,
  input  logic                          en_addr_i,
  input  logic                          req_ready_i,
  output logic                          wr_req_o,
  output logic                          rd_req_o,
  output logic [ROW_W+BANK_W+COL_W-1:0] addr_o,
  output logic [SIZE_W-1:0]             size_o,
  output logic [DW-1:0]                 wdata_o,
  output logic [DW/8-1:0]               be_o,
  input  logic                          rdata_valid_i,
  input  logic [DW-1:0]                 rdata_i,
  output logic                          done_o,
  output logic                          fail_o
);

  localparam int AW    = ROW_W + BANK_W + COL_W;
  localparam int NB    = DW / 8;
  localparam int N_SEQ = MAX_ROW * MAX_BANK * MAX_COL;
  localparam int MAXN  = (N_SEQ > MASK_LOCS) ? ((N_SEQ > AW) ? N_SEQ : AW)
                                             : ((MASK_LOCS > AW) ? MASK_LOCS : AW);
  localparam int IDX_W = $clog2(MAXN + 1);
  localparam int CW    = $clog2(RD_DEPTH + 1);

  fsm_e             state_q;
  phase_e           phase_q, phase_nxt;
  stage_e           stage;
  logic [IDX_W-1:0] issue_idx_q, loc_cnt;
  logic [AW-1:0]    g_addr;
  logic [DW-1:0]    g_wdata, g_exp, exp_q;
  logic [NB-1:0]    g_be;
  logic [CW-1:0]    out_cnt;
  logic             busy, fire, rd_fire, more, room, load_ok;
  fsm_e             after_issue;

  memtest_phase_sel u_sel (
    .cur_i     (phase_q),
    .en_seq_i  (en_seq_i),
    .en_mask_i (en_mask_i),
    .en_addr_i (en_addr_i),
    .nxt_o     (phase_nxt)
  );

  memtest_pattern #(
    .ROW_W     (ROW_W),
    .BANK_W    (BANK_W),
    .COL_W     (COL_W),
    .MAX_ROW   (MAX_ROW),
    .MAX_BANK  (MAX_BANK),
    .MAX_COL   (MAX_COL),
    .MASK_LOCS (MASK_LOCS),
    .DW        (DW),
    .IDX_W     (IDX_W)
  ) u_pat (
    .phase_i (phase_q),
    .stage_i (stage),
    .idx_i   (issue_idx_q),
    .addr_o  (g_addr),
    .wdata_o (g_wdata),
    .be_o    (g_be),
    .exp_o   (g_exp),
    .count_o (loc_cnt)
  );

  memtest_rdcheck #(
    .DW    (DW),
    .DEPTH (RD_DEPTH)
  ) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (rd_fire),
    .push_data_i (exp_q),
    .beat_i      (rdata_valid_i),
    .beat_data_i (rdata_i),
    .cnt_o       (out_cnt),
    .fail_o      (fail_o)
  );

  assign busy    = wr_req_o | rd_req_o;
  assign fire    = busy & req_ready_i;
  assign rd_fire = rd_req_o & req_ready_i;
  assign more    = issue_idx_q < loc_cnt;
  // Conservative: a pop in the same cycle is not counted as free space.
  assign room    = ({1'b0, out_cnt} + (CW+1)'(rd_fire)) < (CW+1)'(RD_DEPTH);
  assign load_ok = more && ((state_q != S_RD) || room);
  assign size_o  = SIZE_W'(1);

  always_comb begin
    case (state_q)
      S_WR2:   stage = ST_WLANE;
      S_RD:    stage = ST_READ;
      default: stage = ST_WFULL;
    endcase
    case (state_q)
      S_WR1:   after_issue = (phase_q == PH_MASK) ? S_WR2 : S_RD;
      S_WR2:   after_issue = S_RD;
      default: after_issue = S_DRAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      phase_q     <= PH_START;
      issue_idx_q <= '0;
      wr_req_o    <= 1'b0;
      rd_req_o    <= 1'b0;
      addr_o      <= '0;
      wdata_o     <= '0;
      be_o        <= '0;
      exp_q       <= '0;
      done_o      <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (init_done_i) state_q <= S_NEXT;
        S_NEXT: begin
          if (phase_nxt == PH_END) begin
            state_q <= S_DONE;
            done_o  <= 1'b1;
          end else begin
            phase_q     <= phase_nxt;
            issue_idx_q <= '0;
            state_q     <= S_WR1;
          end
        end
        S_WR1, S_WR2, S_RD: begin
          if (!busy || fire) begin
            if (load_ok) begin
              wr_req_o    <= (state_q != S_RD);
              rd_req_o    <= (state_q == S_RD);
              addr_o      <= g_addr;
              wdata_o     <= g_wdata;
              be_o        <= g_be;
              exp_q       <= g_exp;
              issue_idx_q <= issue_idx_q + 1'b1;
            end else begin
              wr_req_o <= 1'b0;
              rd_req_o <= 1'b0;
              if (!more) begin
                issue_idx_q <= '0;
                state_q     <= after_issue;
              end
            end
          end
        end
        S_DRAIN: if (out_cnt == '0) state_q <= S_NEXT;
        default: ;
      endcase
    end
  end

  // R3: a write waiting for ready holds its content
  p_hold_wr_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_req_o && !req_ready_i) |=> (wr_req_o && $stable(addr_o) && $stable(wdata_o) && $stable(be_o)));

  // R3: a read waiting for ready holds its address
  p_hold_rd_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !req_ready_i) |=> (rd_req_o && $stable(addr_o)));

  // R3: never both kinds at once
  p_one_kind_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_req_o, rd_req_o}));

  // R12: completion is sticky
  p_done_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  // R12: completion only with nothing in flight and nothing presented
  p_done_drained_r12: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((out_cnt == '0) && !wr_req_o && !rd_req_o));

endmodule

// File: tb/memtest_driver_bench.sv
`timescale 1ns/1ps
module memtest_driver_bench;

  localparam int AW = 9;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          init_done_i = 1'b0;
  logic          en_seq_i = 1'b0, en_mask_i = 1'b0, en_addr_i = 1'b0;
  logic          req_ready_i = 1'b0;
  logic          wr_req_o, rd_req_o;
  logic [AW-1:0] addr_o;
  logic [1:0]    size_o;
  logic [DW-1:0] wdata_o;
  logic [3:0]    be_o;
  logic          rdata_valid_i = 1'b0;
  logic [DW-1:0] rdata_i = '0;
  logic          done_o, fail_o;

  always #2.5 clk = ~clk;

  memtest_driver u_memtest_driver (
    .clk(clk), .rst(rst), .init_done_i(init_done_i),
    .en_seq_i(en_seq_i), .en_mask_i(en_mask_i), .en_addr_i(en_addr_i),
    .req_ready_i(req_ready_i), .wr_req_o(wr_req_o), .rd_req_o(rd_req_o),
    .addr_o(addr_o), .size_o(size_o), .wdata_o(wdata_o), .be_o(be_o),
    .rdata_valid_i(rdata_valid_i), .rdata_i(rdata_i),
    .done_o(done_o), .fail_o(fail_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  bit          q_wr[$];
  logic [31:0] q_addr[$], q_data[$];
  logic [3:0]  q_be[$];
  string       q_tag[$];

  logic [31:0] r_data[$], r_exp[$];
  int          r_due[$];

  logic [31:0] mem_m [logic [31:0]];

  bit run_on = 0, pre_init = 0, done_seen = 0, model_fail = 0, ready_rand = 0;
  int corrupt_at = -1, beat_no = 0, outst = 0, last_due = 0;
  logic [15:0] lfsr = 16'hACE1;

  bit          prev_pend = 0, p_wr, p_rd;
  logic [31:0] p_addr, p_data;
  logic [3:0]  p_be;

  function automatic logic [31:0] pat(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_A5A5;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_exp(bit w, logic [31:0] a, logic [31:0] d, logic [3:0] be, string t);
    q_wr.push_back(w); q_addr.push_back(a); q_data.push_back(d);
    q_be.push_back(be); q_tag.push_back(t);
  endtask

  // Expected request stream, in phase order (R10)
  task automatic build(bit es, bit em, bit ea);
    if (es) begin
      for (int pass = 0; pass < 2; pass++)
        for (int r = 0; r < 2; r++)
          for (int b = 0; b < 2; b++)
            for (int c = 0; c < 4; c++) begin
              logic [31:0] a;
              a = (r << 5) | (b << 3) | c;
              push_exp(pass == 0, a, pat(a), 4'hF, "R4");
            end
    end
    if (em) begin
      for (int i = 0; i < 8; i++) push_exp(1, i, pat(i), 4'hF, "R6 full");
      for (int i = 0; i < 8; i++) push_exp(1, i, ~pat(i), 4'(1 << (i % 4)), "R6 lane");
      for (int i = 0; i < 8; i++) begin
        logic [31:0] m;
        m = 32'hFF << (8 * (i % 4));
        push_exp(0, i, pat(i) ^ m, 4'hF, "R6 read");
      end
    end
    if (ea) begin
      for (int i = 0; i < AW; i++) push_exp(1, 32'(1) << i, 32'(1) << i, 4'hF, "R8");
      for (int i = 0; i < AW; i++) push_exp(0, 32'(1) << i, 32'(1) << i, 4'hF, "R8");
    end
  endtask

  // Cycle monitor and memory model
  initial forever begin
    @(negedge clk);
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (run_on) begin
      bit rdy;
      chk(fail_o == model_fail, "R11 fail flag", 32'(fail_o), 32'(model_fail));
      if (prev_pend)
        chk(wr_req_o == p_wr && rd_req_o == p_rd && addr_o == p_addr[AW-1:0] &&
            (!p_wr || (wdata_o == p_data && be_o == p_be)),
            "R3 held request", 32'(addr_o), p_addr);
      chk(!(wr_req_o && rd_req_o), "R3 both kinds", {wr_req_o, rd_req_o}, 0);
      if (pre_init) chk(!wr_req_o && !rd_req_o, "R2 request before init", {wr_req_o, rd_req_o}, 0);
      if (done_seen) chk(done_o, "R12 done sticky", 32'(done_o), 1);
      if (done_o && !done_seen) begin
        done_seen = 1;
        chk(q_wr.size() == 0 && r_due.size() == 0, "R12 done before last read",
            q_wr.size() + r_due.size(), 0);
      end
      rdy = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
      req_ready_i = rdy;
      if ((wr_req_o || rd_req_o) && rdy) begin
        if (q_wr.size() == 0) begin
          chk(0, "R5 R7 R9 R12 unexpected request", 32'(addr_o), 0);
        end else begin
          bit w; logic [31:0] a, d; logic [3:0] be; string t;
          w = q_wr.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
          be = q_be.pop_front(); t = q_tag.pop_front();
          chk(wr_req_o == w, {t, " R10 kind"}, 32'(wr_req_o), 32'(w));
          chk(32'(addr_o) == a, {t, " R10 address"}, 32'(addr_o), a);
          chk(size_o == 2'd1, "R3 size", 32'(size_o), 1);
          if (wr_req_o) begin
            logic [31:0] old;
            chk(wdata_o == d, {t, " write data"}, wdata_o, d);
            chk(be_o == be, {t, " byte enables"}, 32'(be_o), 32'(be));
            old = mem_m.exists(32'(addr_o)) ? mem_m[32'(addr_o)] : 32'h0;
            for (int b = 0; b < 4; b++) if (be_o[b]) old[8*b +: 8] = wdata_o[8*b +: 8];
            mem_m[32'(addr_o)] = old;
          end else begin
            int due;
            chk(outst < 4, "R13 reads in flight", outst + 1, 4);
            outst++;
            due = cyc + 2 + int'(lfsr[5:4]);
            if (due <= last_due) due = last_due + 1;
            last_due = due;
            r_due.push_back(due);
            r_data.push_back(mem_m.exists(32'(addr_o)) ? mem_m[32'(addr_o)] : 32'h0);
            r_exp.push_back(d);
          end
        end
      end
      prev_pend = (wr_req_o || rd_req_o) && !rdy;
      p_wr = wr_req_o; p_rd = rd_req_o; p_addr = 32'(addr_o); p_data = wdata_o; p_be = be_o;
      if (r_due.size() > 0 && r_due[0] <= cyc) begin
        logic [31:0] v, e;
        void'(r_due.pop_front());
        v = r_data.pop_front(); e = r_exp.pop_front();
        if (beat_no == corrupt_at) v = v ^ 32'h0000_0100;
        beat_no++;
        outst--;
        if (v != e) model_fail = 1;
        rdata_valid_i = 1'b1;
        rdata_i = v;
      end else begin
        rdata_valid_i = 1'b0;
      end
    end
  end

  task automatic apply_reset();
    @(negedge clk); #1;
    run_on = 0; rst = 1; init_done_i = 0; req_ready_i = 0; rdata_valid_i = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!wr_req_o && !rd_req_o && !done_o && !fail_o, "R1 reset state",
        {wr_req_o, rd_req_o, done_o, fail_o}, 0);
    q_wr.delete(); q_addr.delete(); q_data.delete(); q_be.delete(); q_tag.delete();
    r_data.delete(); r_exp.delete(); r_due.delete(); mem_m.delete();
    done_seen = 0; model_fail = 0; beat_no = 0; outst = 0; last_due = 0; prev_pend = 0;
    rst = 0;
    @(negedge clk); #1;
    chk(!wr_req_o && !rd_req_o && !done_o && !fail_o, "R1 after reset release",
        {wr_req_o, rd_req_o, done_o, fail_o}, 0);
    pre_init = 1; run_on = 1;
  endtask

  task automatic run(bit es, bit em, bit ea, bit rr, int corrupt, bit exp_fail);
    en_seq_i = es; en_mask_i = em; en_addr_i = ea; ready_rand = rr;
    apply_reset();
    build(es, em, ea);
    corrupt_at = corrupt;
    repeat (6) @(negedge clk);
    #1;
    pre_init = 0; init_done_i = 1;
    for (int k = 0; k < 20000 && !done_seen; k++) @(negedge clk);
    repeat (10) @(negedge clk);
    #1;
    chk(done_seen, "R12 completion", 32'(done_seen), 1);
    chk(q_wr.size() == 0, "R4 R6 R8 requests missing", q_wr.size(), 0);
    chk(fail_o == exp_fail, "R11 final flag", 32'(fail_o), 32'(exp_fail));
  endtask

  initial begin
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL R12 watchdog actual=%0d expected=<150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run(1, 1, 1, 0, -1, 0);   // R4 R6 R8 R10 full run, always ready
    run(1, 1, 1, 1, 20, 1);   // R11 corrupt beat in byte-lane reads, backpressure
    run(0, 1, 0, 1, -1, 0);   // R5 R9 only byte-lane phase
    run(1, 0, 1, 1, -1, 0);   // R7 byte-lane skipped
    run(0, 0, 1, 0, 3, 1);    // R8 R11 address phase alone with a bad beat
    run(0, 0, 0, 0, -1, 0);   // R12 nothing enabled
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule